// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block gathers the display data for one 64-column slice of a dot-matrix LCD. Several identical slices sit side by side on a shared 4-bit data bus to cover a wider panel. A token travels along the chain and decides which slice accepts nibbles. A slice picks up the token when its chain input is high at a falling edge of the enable clock. It then accepts one nibble on each falling edge of the shift clock. After its sixteenth nibble it raises its chain output, which is the next slice's chain input, and it ignores any further data.

A falling edge on the line latch input copies the collected row into an output latch and drops the token and the chain output, ready for the next line. The latch also captures the AC-drive frame polarity. Each column output is a 2-bit level code built from the latched bit and that polarity, and an analog stage outside this block uses it to pick a drive level.

All strobe inputs are plain levels sampled on the system clock. The block finds their falling edges itself. The system clock must run fast enough that every high and low phase of those strobes spans at least one system clock cycle.

Top module: `lcd_col_slice`

## Requirements
- R1: While the slice holds the token, each falling edge of `shift_clk` takes `nib_in`. In a complete line, nibble k (counting from 0) lands in columns 4k to 4k+3, with `nib_in[0]` in column 4k.
- R2: A falling edge of `enable_clk` gives the slice the token only if `chain_in` is high at that edge. With `chain_in` low, the nibbles that follow do not change the row that is latched next.
- R3: Without the token, shift clock edges leave the collected row unchanged, as seen in the outputs after the next line latch.
- R4: `chain_out` is low after the 15th nibble of a line and high once the 16th nibble has been taken.
- R5: While `chain_out` is high, it stays high and further nibbles are ignored until a line latch falling edge.
- R6: A falling edge of `line_latch` copies the row into the output latch and clears the token and `chain_out`. `col_code` changes at no other time.
- R7: Column c drives `col_code[2c+1:2c]` = {latched bit, frame polarity captured at the same latch edge}. The codes are 00 for the inner level with polarity low, 01 for the inner level with polarity high, 10 for the outer rail with polarity low and 11 for the outer rail with polarity high.
- R8: After reset, `chain_out` is 0 and every `col_code` field is 00.
- R9: A strobe held low for several system clock cycles counts as one edge, so only one nibble is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Data shift strobe, active on its falling edge |
| nib_in | input | 4 | Display data nibble |
| enable_clk | input | 1 | Token capture strobe, active on its falling edge |
| chain_in | input | 1 | Token input from the previous slice, active high |
| line_latch | input | 1 | Line transfer strobe, active on its falling edge |
| frame_pol | input | 1 | AC-drive frame polarity |
| chain_out | output | 1 | Token hand-off to the next slice, active high |
| col_code | output | 128 | Two-bit level code for each of the 64 columns |

## Verification
The assertions assume that a shift edge and a line latch edge never fall in the same system clock cycle. They also assume that each strobe stays at every level for at least one system clock, so that every edge is seen once. The stimulus drives every strobe for whole clock periods, with a high phase between edges. It issues the line latch only after the shift activity has settled, and it lets the frame polarity change only together with a latch. Under these conditions the output codes depend only on latch edges, and the token counts only edges the block actually saw.

// File: rtl/lcdcol_pkg.sv
// Shared types for the LCD column slice: per-column level code encoding.
// Assumes: codes are consumed by an external analog selector.
package lcdcol_pkg;
    typedef enum logic [1:0] {
        LVL_INNER_LO = 2'b00,
        LVL_INNER_HI = 2'b01,
        LVL_OUTER_LO = 2'b10,
        LVL_OUTER_HI = 2'b11
    } lvl_code_t;

    // Pick the drive level for one column from its pixel bit and the frame polarity.
    function automatic lvl_code_t make_code(input logic on, input logic pol);
        if (on) return pol ? LVL_OUTER_HI : LVL_OUTER_LO;
        else    return pol ? LVL_INNER_HI : LVL_INNER_LO;
    endfunction
endpackage

// File: rtl/lcdcol_fall_det.sv
// Falling-edge finder for one strobe sampled on the system clock.
// Assumes: each strobe level lasts at least one clk cycle. The history bit resets
// low, so a strobe that is low when reset ends produces no edge.
module lcdcol_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic fall
);
    logic prev;

    // Remember the strobe level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig_in;
    end

    assign fall = prev & ~sig_in;
endmodule

// File: rtl/lcdcol_token_ctl.sv
// Chain token control: takes the token on an enable edge, counts the nibbles
// accepted, and hands the token on after the last stage is filled.
// Assumes: the line latch edge has priority and clears all token state.
module lcdcol_token_ctl #(
    parameter int STAGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_fall,
    input  logic chain_in,
    input  logic shift_fall,
    input  logic latch_fall,
    output logic hold,
    output logic chain_out
);
    localparam int CNT_W = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAGES - 1);

    logic             armed;
    logic             full;
    logic [CNT_W-1:0] cnt;

    assign hold      = armed & ~full;
    assign chain_out = full;

    // Token capture, nibble counting and hand-off; the latch edge clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            full  <= 1'b0;
            cnt   <= '0;
        end else if (latch_fall) begin
            armed <= 1'b0;
            full  <= 1'b0;
            cnt   <= '0;
        end else begin
            if (en_fall && chain_in) armed <= 1'b1;
            if (hold && shift_fall) begin
                if (cnt == LAST) begin
                    full <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcdcol_nibble_sr.sv
// Nibble-wide shift chain: new data enters the top stage and moves toward
// stage 0, so after STAGES shifts the first nibble sits in stage 0.
// Assumes: the caller shifts only while the slice holds the token.
module lcdcol_nibble_sr #(
    parameter int STAGES = 16,
    parameter int NIB_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic [NIB_W-1:0]          nib,
    output logic [STAGES*NIB_W-1:0]   row
);
    logic [NIB_W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [NIB_W-1:0] next_val;
        if (i == STAGES - 1) begin : g_top
            assign next_val = nib;
        end else begin : g_mid
            assign next_val = stage[i+1];
        end

        // Move one stage toward column 0 on each accepted shift.
        always_ff @(posedge clk) begin
            if (!rst_n)        stage[i] <= '0;
            else if (shift_en) stage[i] <= next_val;
        end

        assign row[i*NIB_W +: NIB_W] = stage[i];
    end
endmodule

// File: rtl/lcdcol_level_out.sv
// Output latch and level-code selection for every column.
// Assumes: load is a single-cycle strobe; the frame polarity is captured with the row.
module lcdcol_level_out #(
    parameter int COLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [COLS-1:0]   row,
    input  logic              frame_in,
    output logic [2*COLS-1:0] codes
);
    import lcdcol_pkg::*;

    logic [COLS-1:0] row_q;
    logic            pol_q;

    // Hold the displayed line and its polarity until the next latch edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            pol_q <= 1'b0;
        end else if (load) begin
            row_q <= row;
            pol_q <= frame_in;
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign codes[2*c +: 2] = make_code(row_q[c], pol_q);
    end
endmodule

// File: rtl/lcd_col_slice.sv
// One cascadable LCD column slice. It finds the strobe edges, runs the token
// chain, shifts in nibbles and latches lines into per-column level codes.
// Assumes: shift and latch edges never fall in the same clk cycle.
module lcd_col_slice #(
    parameter int COLS  = 64,
    parameter int NIB_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic              enable_clk,
    input  logic              chain_in,
    input  logic              line_latch,
    input  logic              frame_pol,
    output logic              chain_out,
    output logic [2*COLS-1:0] col_code
);
    localparam int STAGES = COLS / NIB_W;
    localparam int N_STB  = 3;

    logic [N_STB-1:0] strobes;
    logic [N_STB-1:0] falls;
    logic             shift_fall;
    logic             en_fall;
    logic             latch_fall;
    logic             hold;
    logic [COLS-1:0]  row;

    assign strobes = {line_latch, enable_clk, shift_clk};

    for (genvar s = 0; s < N_STB; s++) begin : g_edge
        lcdcol_fall_det u_fd (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (strobes[s]),
            .fall   (falls[s])
        );
    end

    assign shift_fall = falls[0];
    assign en_fall    = falls[1];
    assign latch_fall = falls[2];

    lcdcol_token_ctl #(.STAGES(STAGES)) u_tok (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_fall    (en_fall),
        .chain_in   (chain_in),
        .shift_fall (shift_fall),
        .latch_fall (latch_fall),
        .hold       (hold),
        .chain_out  (chain_out)
    );

    lcdcol_nibble_sr #(.STAGES(STAGES), .NIB_W(NIB_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (hold & shift_fall),
        .nib      (nib_in),
        .row      (row)
    );

    lcdcol_level_out #(.COLS(COLS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (latch_fall),
        .row      (row),
        .frame_in (frame_pol),
        .codes    (col_code)
    );
endmodule

// File: rtl/lcd_col_slice_chk.sv
// Property checker for the column slice, bound to every lcd_col_slice instance.
// Assumes: the input conditions listed in the brief's verification section.
module lcd_col_slice_chk #(
    parameter int COLS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_fall,
    input logic              latch_fall,
    input logic              hold,
    input logic              chain_out,
    input logic [COLS-1:0]   row,
    input logic [2*COLS-1:0] col_code
);
    // R6: the outputs move only on a latch edge
    a_r6_codes_only_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_fall |=> $stable(col_code));

    // R6: a latch edge drops the hand-off
    a_r6_chain_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        latch_fall |=> !chain_out);

    // R3: no accepted shift means the row is frozen
    a_r3_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && shift_fall) |=> $stable(row));

    // R5: hand-off stays up until a latch edge
    a_r5_chain_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_out && !latch_fall) |=> chain_out);

    // R5: a full slice never accepts data
    a_r5_full_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        chain_out |-> !hold);

    // R4: hand-off rises only as the result of an accepted nibble
    a_r4_rise_from_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_out) |-> $past(hold && shift_fall));
endmodule

bind lcd_col_slice lcd_col_slice_chk #(.COLS(COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_fall (shift_fall),
    .latch_fall (latch_fall),
    .hold       (hold),
    .chain_out  (chain_out),
    .row        (row),
    .col_code   (col_code)
);

// File: tb/lcd_col_slice_tb.sv
module lcd_col_slice_tb;
    localparam int COLS  = 64;
    localparam int NIB_W = 4;
    localparam int NSTG  = COLS / NIB_W;

    typedef struct {
        logic [2*COLS-1:0] code;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              shift_clk = 1'b1;
    logic [NIB_W-1:0]  nib_in = '0;
    logic              enable_clk = 1'b1;
    logic              chain_in = 1'b0;
    logic              line_latch = 1'b1;
    logic              frame_pol = 1'b0;
    logic              chain_out;
    logic [2*COLS-1:0] col_code;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    exp_t sb_q[$];

    // Bench model state, kept from the requirements alone.
    logic [COLS-1:0]   m_row = '0;
    bit                m_tok = 0;
    bit                m_full = 0;
    int                m_cnt = 0;
    logic [2*COLS-1:0] m_shown = '0;

    always #5 clk = ~clk;

    lcd_col_slice #(.COLS(COLS), .NIB_W(NIB_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_clk  (shift_clk),
        .nib_in     (nib_in),
        .enable_clk (enable_clk),
        .chain_in   (chain_in),
        .line_latch (line_latch),
        .frame_pol  (frame_pol),
        .chain_out  (chain_out),
        .col_code   (col_code)
    );

    // Expected codes per R7: field c = {bit c, polarity}.
    function automatic logic [2*COLS-1:0] codes_of(logic [COLS-1:0] r, logic p);
        logic [2*COLS-1:0] v;
        for (int c = 0; c < COLS; c++) v[2*c +: 2] = {r[c], p};
        return v;
    endfunction

    task automatic check(string tag, logic [2*COLS-1:0] act, logic [2*COLS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_nib(logic [NIB_W-1:0] n, int low_cycles);
        shift_clk = 1'b0;
        nib_in    = n;
        repeat (low_cycles) @(negedge clk);
        shift_clk = 1'b1;
        @(negedge clk);
        if (m_tok && !m_full) begin
            m_row[m_cnt*NIB_W +: NIB_W] = n;
            m_cnt++;
            if (m_cnt == NSTG) m_full = 1;
        end
    endtask

    task automatic give_token(logic v);
        chain_in   = v;
        enable_clk = 1'b0;
        @(negedge clk);
        enable_clk = 1'b1;
        chain_in   = 1'b0;
        @(negedge clk);
        if (v) m_tok = 1;
    endtask

    // Driver: issue a line latch and queue the expected outputs for the monitor.
    task automatic do_latch(logic pol, string tag);
        exp_t e;
        frame_pol  = pol;
        line_latch = 1'b0;
        @(posedge clk);
        m_shown = codes_of(m_row, pol);
        m_tok = 0; m_full = 0; m_cnt = 0;
        e.code = m_shown;
        e.tag  = tag;
        sb_q.push_back(e);
        @(negedge clk);
        line_latch = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, col_code, e.code);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 chain_out after reset", {127'b0, chain_out}, '0);
        check("R8 codes after reset", col_code, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Line 1: full load, nibble value = index (R1, R4)
        give_token(1'b1);
        for (int k = 0; k < NSTG - 1; k++) put_nib(NIB_W'(k), 1);
        check("R4 chain_out low after 15th nibble", {127'b0, chain_out}, '0);
        put_nib(4'hF, 1);
        check("R4 chain_out high after 16th nibble", {127'b0, chain_out}, 128'd1);
        put_nib(4'h3, 1);
        check("R5 chain_out held while full", {127'b0, chain_out}, 128'd1);
        check("R6 codes unchanged before latch", col_code, m_shown);
        do_latch(1'b0, "R1 R5 R7 line 1 polarity low");
        check("R6 chain_out cleared by latch", {127'b0, chain_out}, '0);

        // No token: shifts must not touch the row (R3)
        for (int k = 0; k < 5; k++) put_nib(4'hA, 1);
        check("R6 codes unchanged by shifts", col_code, m_shown);
        do_latch(1'b1, "R3 R7 row kept, polarity high");

        // Enable edge with chain_in low gives no token (R2)
        give_token(1'b0);
        for (int k = 0; k < 3; k++) put_nib(4'h5, 1);
        check("R2 no hand-off without token", {127'b0, chain_out}, '0);
        do_latch(1'b0, "R2 row kept after refused token");

        // Long-low shift strobe counts once (R9)
        give_token(1'b1);
        put_nib(4'h9, 4);
        for (int k = 1; k < NSTG - 1; k++) put_nib(4'h6, 1);
        check("R9 chain_out low after 15 edges", {127'b0, chain_out}, '0);
        put_nib(4'hC, 1);
        check("R9 chain_out high after 16 edges", {127'b0, chain_out}, 128'd1);
        do_latch(1'b1, "R9 R1 line with long strobe");

        // Alternating pattern (R1, R7)
        give_token(1'b1);
        for (int k = 0; k < NSTG; k++) begin
            logic [NIB_W-1:0] pat [4];
            pat[0] = 4'h5; pat[1] = 4'hA; pat[2] = 4'h0; pat[3] = 4'hF;
            put_nib(pat[k % 4], 1);
        end
        do_latch(1'b1, "R1 R7 alternating line");
        check("R6 chain_out cleared after last line", {127'b0, chain_out}, '0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule